// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

This block is a single pulse-width timer channel. A down-counter steps once per
tick-enable cycle from a programmed terminal value to zero. A comparator against
an active compare register sets the level of the output pin, and an
end-of-period pulse marks every underflow. Software-side writes never reach the
running counter directly. They land in a count buffer and a compare buffer,
which are copied into the active registers only by a manual-update bit or by an
auto-reload at underflow. This gives glitch-free retiming of period and duty.

A 4-bit control word carries the start, manual-update, output-invert and
auto-reload bits. A parameter moves auto-reload down to bit 2 for a channel that
has no inverter. Enabling takes two control writes: one with manual update and
no start to prime the active registers, then one with start and auto-reload.
Clearing auto-reload lets the current period run out, then parks the channel.
The prescaler, clock selection and register decode sit outside the block. They
deliver the tick enable and the write strobes.

Top module: `pwm_dbuf_channel`

## Requirements
- R1: After reset the control word is 4'b0100 (invert set, all else clear; 4'b0000 when the channel has no inverter), the count buffer holds 1, the compare buffer, counter and active compare hold 0, `pwmOut` is low and `periodEnd` is low.
- R2: With start (bit 0) set, manual update (bit 1) clear and the channel not halted, the counter drops by one on each clock where `tickEn` is high. Reaching zero and ticking again is an underflow, so a period lasts count-buffer + 1 ticks. `periodEnd` is high for exactly the one clock after each underflow tick.
- R3: The raw level is high while counter <= active compare. `pwmOut` equals the raw level XOR the invert bit (bit 2). With invert set, the pin is high for count - compare ticks of each period.
- R4: Writes to the count or compare buffer leave the counter, the active compare and `pwmOut` untouched until a manual update or a reloading underflow. A write in the same clock as a load is seen by the next load only.
- R5: While manual update is set, every clock copies both buffers into the active registers, clears the halt state and holds counting. Counting restarts on the first tick after the bit is cleared with start set.
- R6: With auto-reload set (bit 3 by default), an underflow copies both buffers into the active registers and the next period starts at once.
- R7: With auto-reload clear, an underflow parks the counter at all ones and halts the channel. No further `periodEnd` pulses occur until a manual update, even with start still set.
- R8: An active compare of all ones keeps the raw level high for the whole period and while halted. A manual update with legal buffer values then brings the raw level low.
- R9: On any load, a compare buffer value that is not all ones but is greater than or equal to the count buffer is loaded as count buffer - 1. A zero-tick duty therefore becomes one tick.
- R10: A count-buffer write of 0 is ignored and the buffer keeps its previous value, so a period is never shorter than two ticks.
- R11: On clocks with `tickEn` low and manual update clear, the counter and the active compare do not change.
- R12: With parameters HAS_INVERT=0 and RELOAD_BIT=2, bit 2 acts as auto-reload, bit 3 has no effect, and `pwmOut` is the raw level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle count enable per timer tick |
| cntBufWe | input | 1 | Count buffer write strobe |
| cntBufWdata | input | CNT_W | Count buffer write value (period ticks minus one) |
| cmpBufWe | input | 1 | Compare buffer write strobe |
| cmpBufWdata | input | CNT_W | Compare buffer write value |
| ctrlWe | input | 1 | Control word write strobe |
| ctrlWdata | input | 4 | Control word: start, manual update, invert, auto-reload |
| pwmOut | output | 1 | PWM pin |
| periodEnd | output | 1 | One-clock pulse after each underflow |

## Verification
A buffer write can arrive in the same clock as the underflow that reloads from
that buffer. A manual-update release can also coincide with the first tick. The
bench provokes both with a pseudo-random phase that writes new count and compare
values on every clock while the channel reloads every two to six cycles. A
behavioural model compares pin and pulse on every clock, so a load that picks up
the freshly written value instead of the old one shows up as a mismatch. A
second instance built as the inverter-less variant runs the same stimulus to
judge the moved auto-reload bit.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  localparam int CTRL_W = 4;
  localparam int START_BIT = 0;
  localparam int MANUAL_BIT = 1;
  localparam int INVERT_BIT = 2;

  // Strobes issued by the control unit to the datapath, one clock each.
  typedef struct packed {
    logic loadAct;    // copy buffers into active counter / compare
    logic decr;       // step counter down
    logic wrapHalt;   // underflow without reload: park counter
    logic underflow;  // counter left zero on a tick
  } pwmStrobe_t;

endpackage

// File: rtl/pwm_chan_ctrl.sv
module pwm_chan_ctrl
  import pwm_chan_pkg::*;
#(
  parameter int RELOAD_BIT = 3,
  parameter bit HAS_INVERT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              ctrlWe,
  input  logic [CTRL_W-1:0] ctrlWdata,
  input  logic              cntZero,
  output pwmStrobe_t        strobe,
  output logic              invertEn,
  output logic              manualOn,
  output logic              startOn,
  output logic              halted,
  output logic              periodEnd
);

  localparam logic [CTRL_W-1:0] CTRL_RST =
    HAS_INVERT ? (CTRL_W'(1) << INVERT_BIT) : '0;

  logic [CTRL_W-1:0] ctrlReg;
  logic reloadOn;
  logic stepOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RST;
    end else if (ctrlWe) begin
      ctrlReg <= ctrlWdata;
    end
  end

  assign startOn  = ctrlReg[START_BIT];
  assign manualOn = ctrlReg[MANUAL_BIT];
  assign reloadOn = ctrlReg[RELOAD_BIT];

  generate
    if (HAS_INVERT) begin : g_inv
      assign invertEn = ctrlReg[INVERT_BIT];
    end else begin : g_noinv
      assign invertEn = 1'b0;
    end
  endgenerate

  assign stepOk = tickEn && startOn && !manualOn && !halted;

  always_comb begin
    strobe.underflow = stepOk && cntZero;
    strobe.decr      = stepOk && !cntZero;
    strobe.wrapHalt  = stepOk && cntZero && !reloadOn;
    strobe.loadAct   = manualOn || (stepOk && cntZero && reloadOn);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halted    <= 1'b0;
      periodEnd <= 1'b0;
    end else begin
      periodEnd <= strobe.underflow;
      if (manualOn) begin
        halted <= 1'b0;
      end else if (strobe.wrapHalt) begin
        halted <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_chan_datapath.sv
module pwm_chan_datapath
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrobe_t       strobe,
  input  logic             cntBufWe,
  input  logic [CNT_W-1:0] cntBufWdata,
  input  logic             cmpBufWe,
  input  logic [CNT_W-1:0] cmpBufWdata,
  input  logic             invertEn,
  output logic             cntZero,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] cmpVal,
  output logic [CNT_W-1:0] cntBufVal,
  output logic             pwmOut
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cntBuf;
  logic [CNT_W-1:0] cmpBuf;
  logic [CNT_W-1:0] counter;
  logic [CNT_W-1:0] cmpAct;
  logic [CNT_W-1:0] cmpLoad;
  logic rawLevel;

  // Shadow buffers; a zero period value is refused.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntBuf <= ONE;
      cmpBuf <= '0;
    end else begin
      if (cntBufWe && (cntBufWdata != '0)) begin
        cntBuf <= cntBufWdata;
      end
      if (cmpBufWe) begin
        cmpBuf <= cmpBufWdata;
      end
    end
  end

  // Duty never rounds to zero: out-of-range compare becomes one tick.
  always_comb begin
    if ((cmpBuf != ALL_ONES) && (cmpBuf >= cntBuf)) begin
      cmpLoad = cntBuf - ONE;
    end else begin
      cmpLoad = cmpBuf;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      counter <= '0;
      cmpAct  <= '0;
    end else if (strobe.loadAct) begin
      counter <= cntBuf;
      cmpAct  <= cmpLoad;
    end else if (strobe.wrapHalt) begin
      counter <= ALL_ONES;
    end else if (strobe.decr) begin
      counter <= counter - ONE;
    end
  end

  assign rawLevel  = (counter <= cmpAct);
  assign pwmOut    = rawLevel ^ invertEn;
  assign cntZero   = (counter == '0);
  assign cntVal    = counter;
  assign cmpVal    = cmpAct;
  assign cntBufVal = cntBuf;

endmodule

// File: rtl/pwm_dbuf_channel.sv
module pwm_dbuf_channel
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RELOAD_BIT = 3,
  parameter bit HAS_INVERT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             cntBufWe,
  input  logic [CNT_W-1:0] cntBufWdata,
  input  logic             cmpBufWe,
  input  logic [CNT_W-1:0] cmpBufWdata,
  input  logic             ctrlWe,
  input  logic [3:0]       ctrlWdata,
  output logic             pwmOut,
  output logic             periodEnd
);

  pwmStrobe_t       strobe;
  logic             invertEn;
  logic             manualOn;
  logic             startOn;
  logic             halted;
  logic             cntZero;
  logic [CNT_W-1:0] cntVal;
  logic [CNT_W-1:0] cmpVal;
  logic [CNT_W-1:0] cntBufVal;

  pwm_chan_ctrl #(
    .RELOAD_BIT(RELOAD_BIT),
    .HAS_INVERT(HAS_INVERT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .ctrlWe   (ctrlWe),
    .ctrlWdata(ctrlWdata),
    .cntZero  (cntZero),
    .strobe   (strobe),
    .invertEn (invertEn),
    .manualOn (manualOn),
    .startOn  (startOn),
    .halted   (halted),
    .periodEnd(periodEnd)
  );

  pwm_chan_datapath #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cntBufWe   (cntBufWe),
    .cntBufWdata(cntBufWdata),
    .cmpBufWe   (cmpBufWe),
    .cmpBufWdata(cmpBufWdata),
    .invertEn   (invertEn),
    .cntZero    (cntZero),
    .cntVal     (cntVal),
    .cmpVal     (cmpVal),
    .cntBufVal  (cntBufVal),
    .pwmOut     (pwmOut)
  );

endmodule

// File: rtl/pwm_dbuf_channel_chk.sv
module pwm_dbuf_channel_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tickEn,
  input logic             manualOn,
  input logic             startOn,
  input logic             halted,
  input logic             periodEnd,
  input logic [CNT_W-1:0] cntVal,
  input logic [CNT_W-1:0] cmpVal,
  input logic [CNT_W-1:0] cntBufVal
);

  localparam logic [CNT_W-1:0] ALL_ONES = '1;

  // R2
  pend_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> !periodEnd);

  // R11
  tick_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !manualOn) |=> $stable(cntVal) && $stable(cmpVal));

  // R7
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !manualOn) |=> halted);

  // R7
  halt_park_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> (cntVal == ALL_ONES));

  // R4
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!manualOn && !(tickEn && startOn && !halted && (cntVal == '0)))
      |=> $stable(cmpVal));

  // R10
  cnt_buf_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntBufVal != '0);

endmodule

bind pwm_dbuf_channel pwm_dbuf_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .manualOn (manualOn),
  .startOn  (startOn),
  .halted   (halted),
  .periodEnd(periodEnd),
  .cntVal   (cntVal),
  .cmpVal   (cmpVal),
  .cntBufVal(cntBufVal)
);

// File: tb/test_pwm_dbuf_channel.sv
module pwm_ref_model #(
  parameter int W  = 16,
  parameter int RB = 3,
  parameter bit HI = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickEn,
  input  logic         cbWe,
  input  logic [W-1:0] cbD,
  input  logic         mbWe,
  input  logic [W-1:0] mbD,
  input  logic         cWe,
  input  logic [3:0]   cD,
  output logic         expOut,
  output logic         expEnd
);
  logic [W-1:0] cb, mb, cnt, cmpv;
  logic [3:0]   c;
  logic         halt;

  function automatic logic [W-1:0] clampCmp(input logic [W-1:0] pb, input logic [W-1:0] qb);
    if (qb != {W{1'b1}} && qb >= pb) return pb - W'(1);
    return qb;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cb = W'(1); mb = '0; cnt = '0; cmpv = '0; halt = 1'b0; expEnd = 1'b0;
      c = HI ? 4'b0100 : 4'b0000;
    end else begin
      expEnd = 1'b0;
      if (c[1]) begin
        cnt = cb; cmpv = clampCmp(cb, mb); halt = 1'b0;
      end else if (tickEn && c[0] && !halt) begin
        if (cnt == '0) begin
          expEnd = 1'b1;
          if (c[RB]) begin
            cnt = cb; cmpv = clampCmp(cb, mb);
          end else begin
            cnt = '1; halt = 1'b1;
          end
        end else begin
          cnt = cnt - W'(1);
        end
      end
      if (cbWe && cbD != '0) cb = cbD;
      if (mbWe) mb = mbD;
      if (cWe) c = cD;
    end
  end

  assign expOut = (cnt <= cmpv) ^ (HI ? c[2] : 1'b0);
endmodule

module test_pwm_dbuf_channel;
  localparam int W = 16;
  localparam logic [W-1:0] ALL = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickEn = 1'b0;
  logic cntBufWe = 1'b0, cmpBufWe = 1'b0, ctrlWe = 1'b0;
  logic [W-1:0] cntBufWdata = '0, cmpBufWdata = '0;
  logic [3:0] ctrlWdata = '0;
  logic pwmOut, periodEnd, pwmOutL, periodEndL;
  logic expOut, expEnd, expOutL, expEndL;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit cmpOn = 1'b0;
  string curReq = "R1";

  always #10 clk = ~clk;

  pwm_dbuf_channel #(.CNT_W(W)) i_pwm_dbuf_channel (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .cntBufWe(cntBufWe), .cntBufWdata(cntBufWdata),
    .cmpBufWe(cmpBufWe), .cmpBufWdata(cmpBufWdata),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .pwmOut(pwmOut), .periodEnd(periodEnd));

  // R12: inverter-less variant, auto-reload at bit 2
  pwm_dbuf_channel #(.CNT_W(W), .RELOAD_BIT(2), .HAS_INVERT(1'b0)) i_pwm_last (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .cntBufWe(cntBufWe), .cntBufWdata(cntBufWdata),
    .cmpBufWe(cmpBufWe), .cmpBufWdata(cmpBufWdata),
    .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .pwmOut(pwmOutL), .periodEnd(periodEndL));

  pwm_ref_model #(.W(W), .RB(3), .HI(1'b1)) m_main (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cbWe(cntBufWe), .cbD(cntBufWdata),
    .mbWe(cmpBufWe), .mbD(cmpBufWdata), .cWe(ctrlWe), .cD(ctrlWdata),
    .expOut(expOut), .expEnd(expEnd));

  pwm_ref_model #(.W(W), .RB(2), .HI(1'b0)) m_last (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cbWe(cntBufWe), .cbD(cntBufWdata),
    .mbWe(cmpBufWe), .mbD(cmpBufWdata), .cWe(ctrlWe), .cD(ctrlWdata),
    .expOut(expOutL), .expEnd(expEndL));

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the models.
  always @(negedge clk) begin
    if (cmpOn && !done) begin
      check(curReq, "pwmOut", int'(pwmOut), int'(expOut));
      check(curReq, "periodEnd", int'(periodEnd), int'(expEnd));
      check("R12", "variant pwmOut", int'(pwmOutL), int'(expOutL));
      check("R12", "variant periodEnd", int'(periodEndL), int'(expEndL));
    end
  end

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wrCtrl(input logic [3:0] v);
    ctrlWe = 1'b1; ctrlWdata = v;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  task automatic wrBufs(input logic [W-1:0] p, input logic [W-1:0] q);
    cntBufWe = 1'b1; cntBufWdata = p; cmpBufWe = 1'b1; cmpBufWdata = q;
    @(negedge clk);
    cntBufWe = 1'b0; cmpBufWe = 1'b0;
  endtask

  // Count pulses and pin-high cycles over a window of the main channel.
  task automatic measure(input int n, output int pulses, output int highs);
    pulses = 0; highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pulses += int'(periodEnd);
      highs  += int'(pwmOut);
    end
  endtask

  task automatic holdPin(input string req, input int n, input logic v);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(req, "pin level", int'(pwmOut), int'(v));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finishRun();
    end
  end

  initial begin
    int p, h;
    int seed;
    idle(3);
    // R1: reset state
    check("R1", "pwmOut at reset", int'(pwmOut), 0);
    check("R1", "periodEnd at reset", int'(periodEnd), 0);
    rstN = 1'b1;
    cmpOn = 1'b1;
    idle(2);
    check("R1", "pwmOut after reset", int'(pwmOut), 0);
    tickEn = 1'b1;

    // R5: two-write enable sequence, period 5 ticks, compare 1
    curReq = "R5";
    wrBufs(16'd4, 16'd1);
    wrCtrl(4'b0110);
    wrCtrl(4'b1101);
    curReq = "R2";
    idle(10);
    measure(25, p, h);
    check("R2", "pulses in 25 cycles", p, 5);
    check("R3", "high cycles in 25", h, 15);

    // R4 / R6: buffer change mid-period, picked up at reload
    curReq = "R4";
    wrBufs(16'd2, 16'd0);
    curReq = "R6";
    idle(12);
    measure(21, p, h);
    check("R6", "pulses after reload", p, 7);
    check("R6", "highs after reload", h, 14);

    // R11: sparse ticks
    curReq = "R11";
    for (int i = 0; i < 30; i++) begin
      tickEn = (i % 3 == 0);
      @(negedge clk);
    end
    for (int i = 0; i < 27; i++) begin
      tickEn = (i % 3 == 0);
      @(negedge clk);
      p = (i == 0) ? int'(periodEnd) : p + int'(periodEnd);
    end
    check("R11", "pulses with one tick in three", p, 3);
    tickEn = 1'b1;

    // R9: compare beyond period clamps to one-tick duty
    curReq = "R9";
    wrBufs(16'd2, 16'd7);
    idle(10);
    measure(21, p, h);
    check("R9", "pulses clamped", p, 7);
    check("R9", "highs clamped", h, 7);

    // R3: invert cleared gives raw level (high for counter<=1: 2 of 3)
    curReq = "R3";
    wrCtrl(4'b1001);
    idle(6);
    measure(21, p, h);
    check("R3", "raw highs", h, 14);
    wrCtrl(4'b1101);

    // R7: clearing auto-reload halts after the current period
    curReq = "R7";
    wrCtrl(4'b0101);
    idle(8);
    measure(20, p, h);
    check("R7", "pulses while halted", p, 0);
    check("R7", "pin while parked", int'(pwmOut), 1);

    // R8: all-ones compare, stop, then manual update
    curReq = "R8";
    wrBufs(16'd2, ALL);
    wrCtrl(4'b0110);
    wrCtrl(4'b1101);
    holdPin("R8", 12, 1'b0);
    wrCtrl(4'b0101);
    holdPin("R8", 10, 1'b0);
    curReq = "R4";
    wrBufs(16'd2, 16'd0);
    holdPin("R4", 4, 1'b0);
    curReq = "R8";
    wrCtrl(4'b0110);
    wrCtrl(4'b0100);
    holdPin("R8", 3, 1'b1);

    // R10: zero period write ignored
    curReq = "R10";
    wrBufs(16'd3, 16'd0);
    wrBufs(16'd0, 16'd0);
    wrCtrl(4'b0110);
    wrCtrl(4'b1101);
    idle(8);
    measure(20, p, h);
    check("R10", "pulses with period kept", p, 5);
    check("R10", "highs with period kept", h, 15);

    // R4: coincident buffer writes and reloads, pseudo-random
    curReq = "R4";
    seed = 12345;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 1103515245 + 12345;
      cntBufWe = 1'b1;
      cntBufWdata = W'((seed >>> 8) & 7) % 6;
      cmpBufWe = ((seed >>> 12) & 1) == 1;
      cmpBufWdata = (((seed >>> 16) & 15) == 15) ? ALL : W'((seed >>> 4) & 7);
      tickEn = ((seed >>> 20) & 3) != 0;
      ctrlWe = ((seed >>> 22) & 15) == 0;
      ctrlWdata = 4'(seed >>> 24);
      @(negedge clk);
    end
    cntBufWe = 1'b0; cmpBufWe = 1'b0; ctrlWe = 1'b0;
    idle(4);
    finishRun();
  end
endmodule